// File: doc/BRIEF.md
# Host Data-Port Burst Engine

This engine sits between a host's 16-bit data port and a coprocessor whose memory is split into several regions. A 16-bit address register, which the host loads, selects the target word. Host writes through the data port pass straight to the selected region. Host reads are served from a 16-word prefetch FIFO. Writing the configuration with the run bit set starts a burst: the engine reloads its remaining-word count and streams region reads into the FIFO. It issues one read per cycle until the FIFO is full or the count runs out.

Host reads use a valid/ready handshake. The host raises `rd_valid` and holds it. The engine raises `rd_ready` in the same cycle as `rd_data` is valid, and the word transfers on the clock edge where both are high. While the FIFO is empty and burst words are still owed, `rd_ready` stays low and the host waits. Host writes use the same handshake on `wr_valid` and `wr_ready`, but the write side never applies back-pressure: a write takes the region port in its own cycle and any prefetch waits.

The region port has no back-pressure. A read issued in one cycle must return its word on `rsp_data` in the following cycle. The interrupt pulse and the FIFO flags are plain outputs for a surrounding status and interrupt block.

Top module: `port_burst_engine`

## Requirements
- R1: After reset the FIFO is empty (`fifo_nonempty`=0, `fifo_full`=0), `irq`=0, `req_valid`=0 and `rd_ready`=1.
- R2: Region is `cfg_value[14:12]`. Codes 0, 1, 5 and 7 drive `req_region` with that code, and code 1 presents only the low 11 address bits with the upper bits zero. With any other code no request is issued: a write is dropped with no address step and no `irq`, and each prefetched word reads as 0.
- R3: Burst length code `cfg_value[3:2]` gives 0→1 word, 1→8 words, 2→16 words and 3→unlimited.
- R4: A config write with `cfg_value[4]`=1 flushes the FIFO, reloads the count and prefetches one region read per cycle until the FIFO holds min(16, length) words. Words come out in address order.
- R5: A config write with `cfg_value[4]`=0 clears the count and empties the FIFO in the next cycle. Any response still in flight is discarded.
- R6: As the host drains words, the FIFO refills toward 16 without exceeding the remaining count. An unlimited burst never ends.
- R7: With `cfg_value[1]`=1, every issued region access (a write, or a prefetch read) steps the address by one, wrapping 0xFFFF→0x0000. With it clear, the address holds.
- R8: `rd_ready` is low while the FIFO is empty and burst words remain. When the count is zero and nothing is in flight, a read is accepted at once and returns 0.
- R9: `wr_ready` is always high. An accepted write to a valid region drives `req_valid`, `req_write` and `req_wdata`=`wr_data` in the same cycle.
- R10: `irq` pulses for one cycle after a burst start, after an accepted write to a valid region, and after a read that leaves the FIFO non-empty.
- R11: `fifo_full` is high exactly when 16 words are held. `fifo_nonempty` is high when at least one word is held.
- R12: `addr_wr` loads `addr_value` into the address register. This takes priority over an address step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_value | input | 16 | Config word: region, length code, run bit, auto-step bit |
| addr_wr | input | 1 | Address register load strobe |
| addr_value | input | 16 | New address |
| wr_valid | input | 1 | Host write word valid |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_data | input | 16 | Host write word |
| rd_valid | input | 1 | Host read request |
| rd_ready | output | 1 | Read word available on rd_data |
| rd_data | output | 16 | Host read word |
| req_valid | output | 1 | Region access this cycle |
| req_write | output | 1 | Region access is a write |
| req_region | output | 3 | Region code of the access |
| req_addr | output | 16 | Region word address |
| req_wdata | output | 16 | Region write word |
| rsp_data | input | 16 | Region read word, one cycle after the request |
| irq | output | 1 | Interrupt pulse |
| fifo_full | output | 1 | FIFO holds 16 words |
| fifo_nonempty | output | 1 | FIFO holds at least one word |

## Verification
The hardest state to reach from the ports is refill under continuous draining. Here a pop, a push of an in-flight response and a new fetch can all fall in the same cycle. The bench reaches it with an unlimited burst in the register region that starts two words below an 11-bit boundary. It then reads forty words back to back, so the refill path, the address mask and the wrap are all exercised at once. A scoreboard predicts every word from its address alone. The invalid-region case is reached by starting a burst with an unused code and then issuing a write: the address that write carries shows whether any step leaked.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int CFG_W      = 16;
  localparam int CFG_INC    = 1;
  localparam int CFG_LEN_LO = 2;
  localparam int CFG_RUN    = 4;
  localparam int CFG_RGN_LO = 12;
  localparam int RGN_W      = 3;

  localparam logic [RGN_W-1:0] RGN_DATA = 3'd0;
  localparam logic [RGN_W-1:0] RGN_IO   = 3'd1;
  localparam logic [RGN_W-1:0] RGN_PROG = 3'd5;
  localparam logic [RGN_W-1:0] RGN_EXT  = 3'd7;

  function automatic logic region_valid(input logic [RGN_W-1:0] r);
    return (r == RGN_DATA) || (r == RGN_IO) || (r == RGN_PROG) || (r == RGN_EXT);
  endfunction
endpackage

// File: rtl/burst_rdfifo.sv
module burst_rdfifo #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             nonempty
);
  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [LVL_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) store[wp] <= push_data;
  end

  assign head     = store[rp];
  assign level    = cnt;
  assign full     = (cnt == LVL_W'(DEPTH));
  assign nonempty = (cnt != '0);
endmodule

// File: rtl/burst_sequencer.sv
module burst_sequencer
  import burst_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DEPTH   = 16,
  parameter int IO_BITS = 11,
  localparam int LVL_W  = $clog2(DEPTH) + 1,
  localparam int CNT_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_value,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_value,
  input  logic              wr_valid,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              req_rd,
  output logic              req_wr,
  output logic [RGN_W-1:0]  region,
  output logic [ADDR_W-1:0] req_addr,
  output logic              pending,
  output logic              pending_zero,
  output logic              drained
);
  localparam logic [CNT_W-1:0]  ENDLESS = '1;
  localparam logic [ADDR_W-1:0] IO_MASK = ADDR_W'((1 << IO_BITS) - 1);

  function automatic logic [CNT_W-1:0] burst_words(input logic [1:0] code);
    case (code)
      2'd0:    return CNT_W'(1);
      2'd1:    return CNT_W'(DEPTH / 2);
      2'd2:    return CNT_W'(DEPTH);
      default: return ENDLESS;
    endcase
  endfunction

  logic [RGN_W-1:0]  region_q;
  logic              inc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  remain_q;
  logic              pend_q, pend_zero_q;
  logic              ok, room, fetch, step;

  assign ok    = region_valid(region_q);
  assign room  = (int'(fifo_level) + int'(pend_q)) < DEPTH;
  assign fetch = (remain_q != '0) && room && !wr_valid && !cfg_wr;
  assign step  = (req_rd || req_wr) && inc_q;

  assign req_rd   = fetch && ok;
  assign req_wr   = wr_valid && ok;
  assign region   = region_q;
  assign req_addr = (region_q == RGN_IO) ? (addr_q & IO_MASK) : addr_q;
  assign pending      = pend_q;
  assign pending_zero = pend_zero_q;
  assign drained      = (remain_q == '0) && !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_q    <= '0;
      inc_q       <= 1'b0;
      addr_q      <= '0;
      remain_q    <= '0;
      pend_q      <= 1'b0;
      pend_zero_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        region_q <= cfg_value[CFG_RGN_LO +: RGN_W];
        inc_q    <= cfg_value[CFG_INC];
        remain_q <= cfg_value[CFG_RUN] ? burst_words(cfg_value[CFG_LEN_LO +: 2]) : '0;
      end else if (fetch && remain_q != ENDLESS) begin
        remain_q <= remain_q - 1'b1;
      end
      if (addr_wr)   addr_q <= addr_value;
      else if (step) addr_q <= addr_q + 1'b1;
      pend_q      <= fetch;
      pend_zero_q <= !ok;
    end
  end
endmodule

// File: rtl/port_burst_engine.sv
module port_burst_engine
  import burst_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int DEPTH   = 16,
  parameter int IO_BITS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [15:0]       cfg_value,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_value,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              req_valid,
  output logic              req_write,
  output logic [2:0]        req_region,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              irq,
  output logic              fifo_full,
  output logic              fifo_nonempty
);
  localparam int LVL_W = $clog2(DEPTH) + 1;

  logic              req_rd, req_wr, pending, pending_zero, drained;
  logic [LVL_W-1:0]  level;
  logic [DATA_W-1:0] head;
  logic              pop, push, rd_fire, irq_q;
  int                lvl_next;
  logic              unused_cfg;

  assign unused_cfg = ^{cfg_value[15], cfg_value[11:5], cfg_value[0]};

  burst_sequencer #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IO_BITS(IO_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_value(cfg_value),
    .addr_wr(addr_wr), .addr_value(addr_value), .wr_valid(wr_valid),
    .fifo_level(level), .req_rd(req_rd), .req_wr(req_wr), .region(req_region),
    .req_addr(req_addr), .pending(pending), .pending_zero(pending_zero),
    .drained(drained)
  );

  assign push = pending;

  burst_rdfifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(cfg_wr), .push(push),
    .push_data(pending_zero ? '0 : rsp_data), .pop(pop), .head(head),
    .level(level), .full(fifo_full), .nonempty(fifo_nonempty)
  );

  assign wr_ready  = 1'b1;
  assign req_valid = req_rd || req_wr;
  assign req_write = req_wr;
  assign req_wdata = wr_data;

  assign rd_ready = fifo_nonempty || drained;
  assign rd_data  = fifo_nonempty ? head : '0;
  assign rd_fire  = rd_valid && rd_ready;
  assign pop      = rd_fire && fifo_nonempty && !cfg_wr;

  assign lvl_next = int'(level) - int'(pop) + int'(push);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else irq_q <= (cfg_wr && cfg_value[CFG_RUN]) || req_wr ||
                  (rd_fire && !cfg_wr && lvl_next != 0);
  end
  assign irq = irq_q;
endmodule

// File: rtl/port_burst_engine_chk.sv
module port_burst_engine_chk #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int IO_BITS = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [15:0]       cfg_value,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              req_valid,
  input logic              req_write,
  input logic [2:0]        req_region,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              irq,
  input logic              fifo_full,
  input logic              fifo_nonempty
);
  // R11
  full_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> fifo_nonempty);
  // R2
  io_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_region == 3'd1) |-> (req_addr >> IO_BITS) == '0);
  // R2
  legal_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_region == 3'd0 || req_region == 3'd1 ||
                   req_region == 3'd5 || req_region == 3'd7));
  // R8
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !fifo_nonempty) |-> rd_data == '0);
  // R10
  start_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_value[4]) |=> irq);
  // R9
  write_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && req_valid) |-> (req_write && req_wdata == wr_data));
  // R5
  cancel_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_value[4]) |=> (!fifo_nonempty && rd_ready));
endmodule

bind port_burst_engine port_burst_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_BITS(IO_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_value(cfg_value),
  .wr_valid(wr_valid), .wr_data(wr_data), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .req_valid(req_valid),
  .req_write(req_write), .req_region(req_region), .req_addr(req_addr),
  .req_wdata(req_wdata), .irq(irq), .fifo_full(fifo_full),
  .fifo_nonempty(fifo_nonempty)
);

// File: tb/port_burst_engine_test.sv
module port_burst_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0, addr_wr = 1'b0, wr_valid = 1'b0, rd_valid = 1'b0;
  logic [15:0] cfg_value = '0, addr_value = '0, wr_data = '0, rsp_data = '0;
  logic wr_ready, rd_ready, req_valid, req_write, irq, fifo_full, fifo_nonempty;
  logic [15:0] rd_data, req_addr, req_wdata;
  logic [2:0] req_region;

  int checks = 0, failures = 0;
  bit done = 1'b0, watch_noreq = 1'b0;
  logic [15:0] rdq[$];
  string       rdtag[$];
  logic [31:0] wrq[$];

  always #2.5 clk = ~clk;

  port_burst_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_value(cfg_value),
    .addr_wr(addr_wr), .addr_value(addr_value), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .req_valid(req_valid),
    .req_write(req_write), .req_region(req_region), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_data(rsp_data), .irq(irq),
    .fifo_full(fifo_full), .fifo_nonempty(fifo_nonempty)
  );

  function automatic logic [15:0] mem_word(input logic [2:0] r, input logic [15:0] a);
    return a ^ (16'(r) << 12);
  endfunction

  always @(posedge clk) rsp_data <= mem_word(req_region, req_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (rdq.size() == 0) check(1'b0, "R4 unexpected read", 32'(rd_data), 0);
      else begin
        logic [15:0] e;
        string t;
        e = rdq.pop_front();
        t = rdtag.pop_front();
        check(rd_data == e, t, 32'(rd_data), 32'(e));
      end
    end
    if (rst_n && req_valid && req_write) begin
      if (wrq.size() == 0) check(1'b0, "R2 unexpected write", 32'({req_addr, req_wdata}), 0);
      else begin
        logic [31:0] w;
        w = wrq.pop_front();
        check({req_addr, req_wdata} == w, "R9 write pass", {req_addr, req_wdata}, w);
      end
    end
    if (rst_n && req_valid && watch_noreq)
      check(1'b0, "R2 request from invalid region", 32'(req_region), 0);
  end

  task automatic set_addr(input logic [15:0] a);
    @(posedge clk); #1 addr_wr = 1'b1; addr_value = a;
    @(posedge clk); #1 addr_wr = 1'b0;
  endtask

  task automatic set_cfg(input logic [2:0] rgn, input logic [1:0] len, input bit run, input bit inc);
    @(posedge clk); #1 cfg_wr = 1'b1;
    cfg_value = {1'b0, rgn, 7'd0, run, len, inc, 1'b0};
    @(posedge clk); #1 cfg_wr = 1'b0;
  endtask

  task automatic read_word(input logic [15:0] exp, input string tag);
    rdq.push_back(exp);
    rdtag.push_back(tag);
    @(posedge clk); #1 rd_valid = 1'b1;
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    @(posedge clk); #1 rd_valid = 1'b0;
  endtask

  task automatic write_word(input logic [15:0] d);
    @(posedge clk); #1 wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    check(wr_ready == 1'b1, "R9 wr_ready", 32'(wr_ready), 1);
    @(posedge clk); #1 wr_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!fifo_nonempty && !fifo_full && !irq && !req_valid && rd_ready,
          "R1 reset state", {fifo_nonempty, fifo_full, irq, req_valid, rd_ready}, 5'b00001);

    // Data region, 8-word burst, auto-step (R3, R4, R10, R11, R12)
    set_addr(16'h0010);
    set_cfg(3'd0, 2'd1, 1'b1, 1'b1);
    @(negedge clk);
    check(irq == 1'b1, "R10 start irq", 32'(irq), 1);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(fifo_nonempty && !fifo_full, "R11 partial flags", {fifo_nonempty, fifo_full}, 2'b10);
    read_word(mem_word(3'd0, 16'h0010), "R4 data word");
    @(negedge clk);
    check(irq == 1'b1, "R10 read irq", 32'(irq), 1);
    for (int i = 1; i < 8; i++) read_word(mem_word(3'd0, 16'h0010 + 16'(i)), "R4 data word");
    @(negedge clk);
    check(irq == 1'b0, "R10 no irq when emptied", 32'(irq), 0);
    check(!fifo_nonempty && rd_ready, "R3 eight-word length", {fifo_nonempty, rd_ready}, 2'b01);
    read_word(16'h0000, "R8 drained read returns zero");

    // Program region, 16 words across the wrap (R7, R8, R11)
    set_addr(16'hFFF8);
    set_cfg(3'd5, 2'd2, 1'b1, 1'b1);
    @(negedge clk);
    check(rd_ready == 1'b0, "R8 stall while empty", 32'(rd_ready), 0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(fifo_full == 1'b1, "R11 full at 16", 32'(fifo_full), 1);
    for (int i = 0; i < 16; i++) read_word(mem_word(3'd5, 16'hFFF8 + 16'(i)), "R7 wrap address");
    @(negedge clk);
    check(!fifo_nonempty, "R3 sixteen-word length", 32'(fifo_nonempty), 0);

    // Register region, unlimited, drained back to back (R2, R6, R5)
    set_addr(16'h0FFE);
    set_cfg(3'd1, 2'd3, 1'b1, 1'b1);
    for (int i = 0; i < 40; i++)
      read_word(mem_word(3'd1, (16'h0FFE + 16'(i)) & 16'h07FF), "R6 refill word");
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(fifo_full == 1'b1, "R6 unlimited keeps filling", 32'(fifo_full), 1);
    set_cfg(3'd1, 2'd3, 1'b0, 1'b1);
    @(negedge clk);
    check(!fifo_nonempty && rd_ready, "R5 cancel flush", {fifo_nonempty, rd_ready}, 2'b01);
    read_word(16'h0000, "R5 read after cancel");

    // External region, single word, then fixed address (R3, R7)
    set_addr(16'h1234);
    set_cfg(3'd7, 2'd0, 1'b1, 1'b1);
    read_word(mem_word(3'd7, 16'h1234), "R3 one-word burst");
    @(negedge clk);
    check(!fifo_nonempty && rd_ready, "R3 one-word length", {fifo_nonempty, rd_ready}, 2'b01);
    set_cfg(3'd7, 2'd1, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++) read_word(mem_word(3'd7, 16'h1235), "R7 no step");

    // Invalid region prefetch yields zeros, no requests, no step (R2)
    set_addr(16'h0040);
    watch_noreq = 1'b1;
    set_cfg(3'd2, 2'd1, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) read_word(16'h0000, "R2 invalid region zero");
    watch_noreq = 1'b0;
    set_cfg(3'd0, 2'd0, 1'b0, 1'b1);
    wrq.push_back({16'h0040, 16'hBEEF});
    write_word(16'hBEEF);

    // Writes with wrap, dropped write, irq (R2, R7, R9, R10)
    set_addr(16'hFFFE);
    wrq.push_back({16'hFFFE, 16'h0A0A});
    write_word(16'h0A0A);
    @(negedge clk);
    check(irq == 1'b1, "R10 write irq", 32'(irq), 1);
    wrq.push_back({16'hFFFF, 16'h0B0B});
    write_word(16'h0B0B);
    wrq.push_back({16'h0000, 16'h0C0C});
    write_word(16'h0C0C);
    set_cfg(3'd3, 2'd0, 1'b0, 1'b1);
    watch_noreq = 1'b1;
    write_word(16'hDEAD);
    @(negedge clk);
    check(irq == 1'b0, "R2 dropped write no irq", 32'(irq), 0);
    watch_noreq = 1'b0;
    set_cfg(3'd0, 2'd0, 1'b0, 1'b1);
    wrq.push_back({16'h0001, 16'h0D0D});
    write_word(16'h0D0D);

    repeat (3) @(posedge clk);
    check(rdq.size() == 0 && wrq.size() == 0, "R9 scoreboard drained",
          32'(rdq.size() + wrq.size()), 0);
    finish_run();
  end
endmodule